// File: doc/BRIEF.md
# One-Wire Slot-Start Front-End

This block sits between a one-wire bus pin, already turned into a logic level, and the bit-slot logic of a slave. It samples the line with the system clock and produces two things: a single-cycle strobe that marks the start of each time slot, and a cleaned copy of the line level. Noise on a long one-wire network shows up as short low spikes and ringing. The block is built to keep such noise from opening false slots.

Two mechanisms reject noise. First, in standard speed a falling edge opens a slot only after the line has stayed low for a set number of consecutive samples; in overdrive speed this qualification is skipped. Second, every return of the line to high starts a hold-off window. During that window low samples are ignored, however long they are. If the line is still low at the first sample after the window, that sample opens a new slot at once. All lengths are clock-cycle counts set by parameters, and the hold-off length has separate values for the two speeds.

Top module: `ow_slot_frontend`

## Requirements
- R1: The raw line passes through a synchroniser of SYNC_STAGES flops (default 2), which resets to high, before any filtering. With the defaults, a low driven into the raw input is first seen by the filter three clock edges later.
- R2: In standard speed (overdrive_i = 0), a low run shorter than STD_LOW_SAMPLES synchronised samples (default 3) produces no slot strobe.
- R3: In standard speed, a low run of at least STD_LOW_SAMPLES samples raises slot_start_o in the cycle after the edge that takes the last qualifying sample. With the defaults, this is five edges after the raw line goes low.
- R4: In overdrive speed (overdrive_i = 1), the low-run qualification is bypassed: a single low sample opens a slot. With the defaults, slot_start_o rises three edges after the raw line goes low.
- R5: slot_start_o is high for exactly one cycle. Only one strobe is produced per accepted low period, however long that period lasts.
- R6: Once the filtered level has returned high, every low sample in the next HOLD_STD_CYC (default 8) or HOLD_OD_CYC (default 3) cycles is ignored. The length is chosen by overdrive_i at the time of the rise.
- R7: The first synchronised sample after the hold-off window decides what happens next. If it is low, that sample opens a slot immediately, with no fresh low-run qualification. If it is high, the block returns to idle.
- R8: line_filt_o is 0 from the cycle in which a slot is accepted until the rise of the line is seen, and 1 at all other times, including during qualification and while low glitches are being ignored.
- R9: The synchronous reset rst returns the block to idle. After reset, line_filt_o is 1, slot_start_o is 0 and no hold-off window is active, so the next low is qualified normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_raw_i | input | 1 | Digitised bus line, asynchronous to clk |
| overdrive_i | input | 1 | 1 selects overdrive timing, 0 selects standard timing |
| slot_start_o | output | 1 | One-cycle strobe when a time slot is accepted |
| line_filt_o | output | 1 | Filtered line level for downstream slot logic |

## Verification
The assertions check the following on every cycle:
- the strobe lasts one cycle and coincides with a low filtered level;
- no strobe appears while the hold-off counter is running;
- a low sample at the end of the window always opens a slot;
- a low sample in overdrive idle always opens a slot;
- the hold-off counter loads the length for the current speed and drains by one per cycle;
- reset clears the state.

Only the bench scenarios can show the following:
- the exact latency through the synchroniser and the low-run filter;
- that two-sample spikes are rejected in standard speed;
- that deep glitches inside the window are ignored, while glitches that outlast it open a slot;
- that a reset in the middle of a window cancels that window.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;

    // Control state of the slot detector.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // line high (or being qualified), waiting for a slot
        ST_LOW  = 2'd1,   // slot accepted, line still low
        ST_HOLD = 2'd2    // line back high, hold-off window in progress
    } slot_state_e;

    // One step of the control path: next state plus the strobes it raises.
    typedef struct packed {
        slot_state_e nxt;
        logic        pulse;
        logic        hold_start;
    } slot_step_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    // Next-step rule of the detector.
    function automatic slot_step_t slot_next(
        input slot_state_e cur,
        input logic        line_high,
        input logic        qualified,
        input logic        hold_active
    );
        slot_step_t s;
        s.nxt        = cur;
        s.pulse      = 1'b0;
        s.hold_start = 1'b0;
        unique case (cur)
            ST_IDLE: begin
                if (qualified) begin
                    s.nxt   = ST_LOW;
                    s.pulse = 1'b1;
                end
            end
            ST_LOW: begin
                if (line_high) begin
                    s.nxt        = ST_HOLD;
                    s.hold_start = 1'b1;
                end
            end
            ST_HOLD: begin
                if (!hold_active) begin
                    if (line_high) begin
                        s.nxt = ST_IDLE;
                    end else begin
                        s.nxt   = ST_LOW;
                        s.pulse = 1'b1;
                    end
                end
            end
            default: s.nxt = ST_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
    parameter int   STAGES      = 2,
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic sync_o
);
    localparam int N = (STAGES < 1) ? 1 : STAGES;

    logic [N-1:0] chain_q;

    generate
        if (N == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= RESET_LEVEL;
                else     chain_q <= raw_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {N{RESET_LEVEL}};
                else     chain_q <= {chain_q[N-2:0], raw_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[N-1];

endmodule

// File: rtl/ow_low_qualifier.sv
module ow_low_qualifier
    import ow_slot_pkg::*;
#(
    parameter int STD_LOW_SAMPLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic armed_i,
    input  logic line_i,
    input  logic overdrive_i,
    output logic qualified_o
);
    localparam int NEED = at_least_one(STD_LOW_SAMPLES);
    localparam int RW   = $clog2(NEED + 1);
    localparam logic [RW-1:0] NEED_V = RW'(NEED);

    logic [RW-1:0] run_q;
    logic [RW-1:0] run_inc;

    assign run_inc     = run_q + RW'(1);
    assign qualified_o = armed_i && !line_i && (overdrive_i || (run_inc >= NEED_V));

    // Counts consecutive low samples while waiting for a slot.
    always_ff @(posedge clk) begin
        if (rst || !armed_i || line_i) begin
            run_q <= '0;
        end else if (!qualified_o) begin
            run_q <= run_inc;
        end
    end

    AST_RUN_BELOW_NEED: assert property (@(posedge clk) disable iff (rst)
        run_q < NEED_V);                                              // R2

    AST_RUN_CLEARED_HIGH: assert property (@(posedge clk) disable iff (rst)
        line_i |=> (run_q == '0));                                    // R2

endmodule

// File: rtl/ow_holdoff_timer.sv
module ow_holdoff_timer
    import ow_slot_pkg::*;
#(
    parameter int HOLD_STD_CYC = 8,
    parameter int HOLD_OD_CYC  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic overdrive_i,
    output logic active_o
);
    localparam int HMAX = max_of(max_of(HOLD_STD_CYC, HOLD_OD_CYC), 1);
    localparam int HW   = $clog2(HMAX + 1);
    localparam logic [HW-1:0] LEN_STD = HW'(HOLD_STD_CYC);
    localparam logic [HW-1:0] LEN_OD  = HW'(HOLD_OD_CYC);

    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= overdrive_i ? LEN_OD : LEN_STD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - HW'(1);
        end
    end

    assign active_o = (cnt_q != '0);

    AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (cnt_q == ($past(overdrive_i) ? LEN_OD : LEN_STD)));   // R6

    AST_HOLD_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (!start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - HW'(1)));   // R6

endmodule

// File: rtl/ow_slot_frontend.sv
module ow_slot_frontend
    import ow_slot_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int STD_LOW_SAMPLES = 3,
    parameter int HOLD_STD_CYC    = 8,
    parameter int HOLD_OD_CYC     = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_raw_i,
    input  logic overdrive_i,
    output logic slot_start_o,
    output logic line_filt_o
);
    slot_state_e state_q;
    slot_step_t  step;
    logic        line_s;
    logic        qualified;
    logic        hold_active;
    logic        slot_start_q;

    ow_line_sync #(
        .STAGES      (SYNC_STAGES),
        .RESET_LEVEL (1'b1)
    ) sync_i (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (line_raw_i),
        .sync_o (line_s)
    );

    ow_low_qualifier #(
        .STD_LOW_SAMPLES (STD_LOW_SAMPLES)
    ) qual_i (
        .clk         (clk),
        .rst         (rst),
        .armed_i     (state_q == ST_IDLE),
        .line_i      (line_s),
        .overdrive_i (overdrive_i),
        .qualified_o (qualified)
    );

    ow_holdoff_timer #(
        .HOLD_STD_CYC (HOLD_STD_CYC),
        .HOLD_OD_CYC  (HOLD_OD_CYC)
    ) hold_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (step.hold_start),
        .overdrive_i (overdrive_i),
        .active_o    (hold_active)
    );

    always_comb begin
        step = slot_next(state_q, line_s, qualified, hold_active);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            slot_start_q <= 1'b0;
        end else begin
            state_q      <= step.nxt;
            slot_start_q <= step.pulse;
        end
    end

    assign slot_start_o = slot_start_q;
    assign line_filt_o  = (state_q != ST_LOW);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (line_filt_o && !slot_start_o && !hold_active));           // R9

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        slot_start_o |=> !slot_start_o);                                    // R5

    AST_FILT_AT_START: assert property (@(posedge clk) disable iff (rst)
        slot_start_o |-> !line_filt_o);                                     // R8

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && hold_active) |=> !slot_start_o);             // R6

    AST_HOLD_DECIDE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && !hold_active && !line_s) |=> slot_start_o);  // R7

    AST_OD_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !line_s && overdrive_i) |=> slot_start_o);   // R4

endmodule

// File: tb/ow_slot_frontend_tb_top.sv
module ow_slot_frontend_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line = 1'b1;
    logic od = 1'b0;
    logic slot_start_o;
    logic line_filt_o;

    always #5 clk = ~clk;

    ow_slot_frontend dut_i (
        .clk          (clk),
        .rst          (rst),
        .line_raw_i   (line),
        .overdrive_i  (od),
        .slot_start_o (slot_start_o),
        .line_filt_o  (line_filt_o)
    );

    typedef struct {
        int    at;
        string req;
    } exp_t;

    exp_t  exp_q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    pulses = 0;
    string cur_req = "R2";
    logic  prev_ss = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Monitor: pops expected strobe cycles and compares them.
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            if (exp_q.size() > 0 && cyc > exp_q[0].at) begin
                e = exp_q.pop_front();
                check(1'b0, e.req, "missed slot start at cycle", -1, e.at);
            end
            if (slot_start_o) begin
                pulses++;
                check(prev_ss == 1'b0, "R5", "strobe longer than one cycle",
                      int'(prev_ss), 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_req, "unexpected slot start at cycle", cyc, -1);
                end else begin
                    e = exp_q.pop_front();
                    check(e.at == cyc, e.req, "slot start cycle", cyc, e.at);
                end
            end
        end
        prev_ss = slot_start_o;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: holds the raw line low for w cycles; off < 0 means no strobe expected.
    task automatic low_pulse(input int w, input int off, input string req);
        int c;
        c = cyc;
        cur_req = req;
        if (off >= 0) exp_q.push_back('{at: c + off, req: req});
        line = 1'b0;
        repeat (w) @(negedge clk);
        line = 1'b1;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int p0;
        repeat (3) @(negedge clk);
        check(line_filt_o == 1'b1, "R9", "line_filt_o in reset", int'(line_filt_o), 1);
        check(slot_start_o == 1'b0, "R9", "slot_start_o in reset", int'(slot_start_o), 0);
        rst = 1'b0;
        idle(4);

        // R2: short lows in standard speed are rejected.
        p0 = pulses;
        low_pulse(1, -1, "R2");
        idle(6);
        low_pulse(2, -1, "R2");
        idle(20);
        check(pulses == p0, "R2", "strobes after 1- and 2-sample lows", pulses, p0);

        // R3 / R1: three-sample low accepted five edges after the drive.
        low_pulse(3, 5, "R3");
        idle(20);

        // R5 / R8: long low gives one strobe; filtered level follows.
        p0 = pulses;
        cur_req = "R5";
        exp_q.push_back('{at: cyc + 5, req: "R5"});
        line = 1'b0;
        idle(10);
        check(line_filt_o == 1'b0, "R8", "line_filt_o during accepted low",
              int'(line_filt_o), 0);
        idle(10);
        line = 1'b1;
        idle(20);
        check(line_filt_o == 1'b1, "R8", "line_filt_o after slot ends",
              int'(line_filt_o), 1);
        check(pulses == p0 + 1, "R5", "strobes for one long low", pulses, p0 + 1);

        // R4 / R1: overdrive bypasses the low-run filter.
        od = 1'b1;
        low_pulse(1, 3, "R4");
        idle(20);

        // R6: deep 8-cycle glitch inside the standard window is ignored.
        od = 1'b0;
        low_pulse(10, 5, "R3");
        idle(1);
        p0 = pulses;
        low_pulse(8, -1, "R6");
        check(line_filt_o == 1'b1, "R8", "line_filt_o during ignored glitch",
              int'(line_filt_o), 1);
        idle(20);
        check(pulses == p0, "R6", "strobes from glitch inside standard window",
              pulses, p0);

        // R7: glitch reaching the deciding sample opens a slot at once.
        low_pulse(10, 5, "R3");
        idle(1);
        low_pulse(9, 11, "R7");
        idle(20);
        low_pulse(10, 5, "R3");
        idle(1);
        low_pulse(12, 11, "R7");
        idle(20);

        // R6 / R7 in overdrive: 3-cycle window.
        od = 1'b1;
        low_pulse(4, 3, "R4");
        idle(1);
        p0 = pulses;
        low_pulse(3, -1, "R6");
        idle(20);
        check(pulses == p0, "R6", "strobes from glitch inside overdrive window",
              pulses, p0);
        low_pulse(4, 3, "R4");
        idle(1);
        low_pulse(4, 6, "R7");
        idle(20);

        // R9: reset in the middle of a hold-off window cancels it.
        od = 1'b0;
        low_pulse(5, 5, "R3");
        idle(4);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        check(line_filt_o == 1'b1, "R9", "line_filt_o after mid-window reset",
              int'(line_filt_o), 1);
        check(slot_start_o == 1'b0, "R9", "slot_start_o after mid-window reset",
              int'(slot_start_o), 0);
        low_pulse(4, 5, "R9");
        idle(30);

        check(exp_q.size() == 0, "R3", "expected strobes left unseen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule